// File: doc/BRIEF.md
# Core Halt and Break Controller

This block decides when a small five-stage in-order scalar core (fetch, register read, execute, data memory, writeback) may run. It holds three status flags: halted, broke and interrupt-on-break enable. It takes status writes from a host and from the core's own coprocessor move. It also takes writes of the program counter from the host and a break indication from the execute stage. From these it drives a halt level, per-stage flush strobes, a redirect strobe with the PC that fetch must restart from, and a one-cycle interrupt request toward the host.

A break does not stop the core in the execute stage. Its halt-plus-broke update is posted as a writeback-time status change. That change lands at the clock edge that closes the break's execute cycle, so the next cycle is already halted. Only the stages behind the break are discarded. The resume PC is the one the execute stage names as the next instruction to run. For a break in a branch delay slot, that is the branch target. A host PC write acts at once: it discards all five stages and replaces the resume PC, even while the core is halted.

Top module: `halt_brk_ctl`

## Requirements
- R1: After reset, halt_o=1, broke_o=0, brk_irq_en_o=0, irq_o=0, flush_o=0 and redirect_o=0. The saved resume PC is 0.
- R2: A break (ex_brk_i=1 while not halted) sets halt_o and broke_o in the next cycle. In that same cycle flush_o bits 2:0 are 1 (bit0 fetch, bit1 read, bit2 execute) and bits 4:3 (data memory, writeback) are 0.
- R3: A break saves ex_next_pc_i as the resume PC; for a break in a delay slot this input carries the branch target. When halt is cleared, redirect_o is 1 for one cycle, in the cycle after the clearing write, with redirect_pc_o equal to the saved PC.
- R4: irq_o pulses for exactly one cycle, in the cycle after a break, if brk_irq_en_o was 1 when the break arrived. A break with the enable at 0 raises no request.
- R5: A host PC write (host_wr_i=1, host_addr_i=1) makes flush_o all ones and redirect_o=1 in the next cycle. The PC is host_data_i[11:0] with bits 1:0 forced to 0. This PC replaces the resume PC, also while halted, and takes priority over a break in the same cycle.
- R6: A status write word (host_addr_i=0, or the core path) uses these bits: bit0 clears halt, bit1 sets halt, bit2 clears broke, bit3 clears the break-interrupt enable, bit4 sets it. When set and clear for the same flag are both 1, clear wins.
- R7: Bit 31 is the internal set-broke bit, used only by a break. It is forced to 0 in core and host status writes, so they never set broke.
- R8: A core status write and a host status write in the same cycle both take effect.
- R9: While halted, ex_brk_i and core_st_wr_i are ignored. Flags, the resume PC, irq_o and flush_o are left unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 1 | Host target: 0 status, 1 program counter |
| host_data_i | input | 32 | Host write data |
| core_st_wr_i | input | 1 | Status write from the core's coprocessor move |
| core_st_data_i | input | 32 | Core status write word |
| ex_brk_i | input | 1 | Break instruction in the execute stage |
| ex_next_pc_i | input | 12 | PC the execute stage would run next |
| halt_o | output | 1 | Core halted |
| broke_o | output | 1 | Halted by a break |
| brk_irq_en_o | output | 1 | Interrupt-on-break enable |
| irq_o | output | 1 | One-cycle interrupt request to host |
| flush_o | output | 5 | Per-stage discard, bit0 fetch to bit4 writeback |
| redirect_o | output | 1 | Fetch restarts at redirect_pc_o |
| redirect_pc_o | output | 12 | Restart PC |

## Verification
Breaks are applied in several ways: with the interrupt enable set and cleared, with a delay-slot target as the next PC, while already halted, and together with a host PC write. Together these show where the resume PC comes from and which stages get flushed. Status words that set and clear the same flag show clear priority. Words carrying bit 31 show that the set-broke bit is masked. A core write landing in the same cycle as a host write shows that both updates merge. A PC write made between halt and unhalt shows that the saved PC is replaced before the later redirect.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  localparam int WORD_W       = 32;
  localparam int NFLAG        = 3;
  localparam int FLAG_HALT    = 0;
  localparam int FLAG_BROKE   = 1;
  localparam int FLAG_IEN     = 2;
  // status word bit positions
  localparam int ST_CLR_HALT  = 0;
  localparam int ST_SET_HALT  = 1;
  localparam int ST_CLR_BROKE = 2;
  localparam int ST_CLR_IEN   = 3;
  localparam int ST_SET_IEN   = 4;
  localparam int ST_SET_BROKE = WORD_W - 1;

  typedef enum logic {HADDR_STATUS = 1'b0, HADDR_PC = 1'b1} haddr_e;

  typedef struct packed {
    logic [NFLAG-1:0] set;
    logic [NFLAG-1:0] clr;
  } flag_req_t;

  function automatic flag_req_t decode_word(input logic [WORD_W-1:0] w);
    flag_req_t r;
    r.set = '0;
    r.clr = '0;
    r.set[FLAG_HALT]  = w[ST_SET_HALT];
    r.clr[FLAG_HALT]  = w[ST_CLR_HALT];
    r.set[FLAG_BROKE] = w[ST_SET_BROKE];
    r.clr[FLAG_BROKE] = w[ST_CLR_BROKE];
    r.set[FLAG_IEN]   = w[ST_SET_IEN];
    r.clr[FLAG_IEN]   = w[ST_CLR_IEN];
    return r;
  endfunction
endpackage

// File: rtl/hbc_flag_bank.sv
module hbc_flag_bank #(
  parameter int NBITS = 3,
  parameter logic [NBITS-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] set_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] q_o
);
  for (genvar i = 0; i < NBITS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           q_o[i] <= RST_VAL[i];
      else if (clr_i[i]) q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
    end

    // R6: clear beats set
    p_clr_wins_r6: assert property (@(posedge clk) disable iff (rst)
      clr_i[i] |=> !q_o[i]);
  end
endmodule

// File: rtl/hbc_pc_ctl.sv
module hbc_pc_ctl #(
  parameter int PC_W        = 12,
  parameter int NSTAGES     = 5,
  parameter int KILL_STAGES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_pc_wr_i,
  input  logic [PC_W-1:0]    host_pc_i,
  input  logic               brk_i,
  input  logic [PC_W-1:0]    brk_pc_i,
  input  logic               unhalt_i,
  output logic [NSTAGES-1:0] flush_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o
);
  localparam logic [PC_W-1:0] ALIGN_MASK = {{(PC_W-2){1'b1}}, 2'b00};

  logic [PC_W-1:0] resume_q;

  always_ff @(posedge clk) begin
    if (rst)               resume_q <= '0;
    else if (host_pc_wr_i) resume_q <= host_pc_i & ALIGN_MASK;
    else if (brk_i)        resume_q <= brk_pc_i & ALIGN_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      redirect_o    <= host_pc_wr_i | unhalt_i;
      redirect_pc_o <= host_pc_wr_i ? (host_pc_i & ALIGN_MASK) : resume_q;
    end
  end

  for (genvar s = 0; s < NSTAGES; s++) begin : g_flush
    localparam bit KILL_ON_BRK = (s < KILL_STAGES);
    always_ff @(posedge clk) begin
      if (rst) flush_o[s] <= 1'b0;
      else     flush_o[s] <= host_pc_wr_i | (brk_i & KILL_ON_BRK);
    end
  end

  // R5: host PC write discards every stage and redirects
  p_pc_flush_all_r5: assert property (@(posedge clk) disable iff (rst)
    host_pc_wr_i |=> (&flush_o && redirect_o));
  // R3: leaving halt always redirects fetch
  p_unhalt_redirect_r3: assert property (@(posedge clk) disable iff (rst)
    unhalt_i |=> redirect_o);
  // R9: saved PC only moves on a break or host PC write
  p_resume_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!host_pc_wr_i && !brk_i) |=> $stable(resume_q));
endmodule

// File: rtl/halt_brk_ctl.sv
module halt_brk_ctl
  import hbc_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int NSTAGES     = 5,
  parameter int KILL_STAGES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_i,
  input  logic               host_addr_i,
  input  logic [31:0]        host_data_i,
  input  logic               core_st_wr_i,
  input  logic [31:0]        core_st_data_i,
  input  logic               ex_brk_i,
  input  logic [PC_W-1:0]    ex_next_pc_i,
  output logic               halt_o,
  output logic               broke_o,
  output logic               brk_irq_en_o,
  output logic               irq_o,
  output logic [NSTAGES-1:0] flush_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o
);
  localparam logic [WORD_W-1:0] USER_MASK = ~(WORD_W'(1) << ST_SET_BROKE);
  localparam logic [WORD_W-1:0] BRK_WORD  =
    (WORD_W'(1) << ST_SET_BROKE) | (WORD_W'(1) << ST_SET_HALT);
  localparam logic [NFLAG-1:0]  FLAG_RST  = NFLAG'(1) << FLAG_HALT;

  logic [NFLAG-1:0]  flags_q;
  logic              brk_eff, core_eff, host_st_wr, host_pc_wr, unhalt;
  logic [WORD_W-1:0] core_word, host_word;
  flag_req_t         core_req, host_req;
  logic [NFLAG-1:0]  set_all, clr_all;

  assign halt_o       = flags_q[FLAG_HALT];
  assign broke_o      = flags_q[FLAG_BROKE];
  assign brk_irq_en_o = flags_q[FLAG_IEN];

  // core-side update: a break or a coprocessor move, both dropped while halted
  assign brk_eff    = ex_brk_i & ~halt_o;
  assign core_eff   = core_st_wr_i & ~halt_o;
  assign core_word  = (core_eff ? (core_st_data_i & USER_MASK) : '0)
                    | (brk_eff ? BRK_WORD : '0);
  assign host_st_wr = host_wr_i & (host_addr_i == HADDR_STATUS);
  assign host_pc_wr = host_wr_i & (host_addr_i == HADDR_PC);
  assign host_word  = host_st_wr ? (host_data_i & USER_MASK) : '0;

  assign core_req = decode_word(core_word);
  assign host_req = decode_word(host_word);
  assign set_all  = core_req.set | host_req.set;
  assign clr_all  = core_req.clr | host_req.clr;
  assign unhalt   = halt_o & clr_all[FLAG_HALT];

  hbc_flag_bank #(.NBITS(NFLAG), .RST_VAL(FLAG_RST)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_all),
    .clr_i (clr_all),
    .q_o   (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= brk_eff & flags_q[FLAG_IEN];
  end

  hbc_pc_ctl #(.PC_W(PC_W), .NSTAGES(NSTAGES), .KILL_STAGES(KILL_STAGES)) u_pc (
    .clk           (clk),
    .rst           (rst),
    .host_pc_wr_i  (host_pc_wr),
    .host_pc_i     (host_data_i[PC_W-1:0]),
    .brk_i         (brk_eff),
    .brk_pc_i      (ex_next_pc_i),
    .unhalt_i      (unhalt),
    .flush_o       (flush_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

  // R2: break halts with broke in the following cycle
  p_brk_halts_r2: assert property (@(posedge clk) disable iff (rst)
    (brk_eff && !host_req.clr[FLAG_HALT] && !host_req.clr[FLAG_BROKE])
      |=> (halt_o && broke_o));
  // R4: request only after a break with the enable set
  p_irq_src_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(brk_eff && flags_q[FLAG_IEN]));
  // R7: broke can only be raised by a break
  p_broke_src_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(broke_o) |-> $past(brk_eff));
  // R9: while halted only the host can move the flags
  p_halted_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (halt_o && !host_st_wr) |=> ($stable(broke_o) && $stable(brk_irq_en_o)));
endmodule

// File: tb/tb_halt_brk_ctl.sv
module tb_halt_brk_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 12;
  localparam int NST  = 5;

  logic clk = 1'b0;
  logic rst;
  logic host_wr_i, host_addr_i, core_st_wr_i, ex_brk_i;
  logic [31:0] host_data_i, core_st_data_i;
  logic [PC_W-1:0] ex_next_pc_i;
  logic halt_o, broke_o, brk_irq_en_o, irq_o, redirect_o;
  logic [NST-1:0] flush_o;
  logic [PC_W-1:0] redirect_pc_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_brk_ctl dut (
    .clk(clk), .rst(rst), .host_wr_i(host_wr_i), .host_addr_i(host_addr_i),
    .host_data_i(host_data_i), .core_st_wr_i(core_st_wr_i),
    .core_st_data_i(core_st_data_i), .ex_brk_i(ex_brk_i),
    .ex_next_pc_i(ex_next_pc_i), .halt_o(halt_o), .broke_o(broke_o),
    .brk_irq_en_o(brk_irq_en_o), .irq_o(irq_o), .flush_o(flush_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  typedef struct packed {
    logic hw; logic ha; logic [31:0] hd;
    logic cw; logic [31:0] cd;
    logic bk; logic [11:0] npc;
    logic eh; logic eb; logic ei; logic eirq;
    logic [4:0] ef; logic er; logic [11:0] erpc;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    // R3 unhalt from reset redirects to 0
    '{1'b1,1'b0,32'h1, 1'b0,32'h0, 1'b0,12'h0,  1'b0,1'b0,1'b0,1'b0,5'h00,1'b1,12'h000, 4'd3},
    '{1'b0,1'b0,32'h0, 1'b0,32'h0, 1'b0,12'h0,  1'b0,1'b0,1'b0,1'b0,5'h00,1'b0,12'h000, 4'd3},
    // R6 set interrupt enable
    '{1'b1,1'b0,32'h10,1'b0,32'h0, 1'b0,12'h0,  1'b0,1'b0,1'b1,1'b0,5'h00,1'b0,12'h000, 4'd6},
    // R2 R4 break with enable
    '{1'b0,1'b0,32'h0, 1'b0,32'h0, 1'b1,12'h124,1'b1,1'b1,1'b1,1'b1,5'h07,1'b0,12'h000, 4'd2},
    // R4 one-cycle pulse
    '{1'b0,1'b0,32'h0, 1'b0,32'h0, 1'b0,12'h0,  1'b1,1'b1,1'b1,1'b0,5'h00,1'b0,12'h000, 4'd4},
    // R9 break and core write while halted ignored
    '{1'b0,1'b0,32'h0, 1'b1,32'h8, 1'b1,12'h300,1'b1,1'b1,1'b1,1'b0,5'h00,1'b0,12'h000, 4'd9},
    // R3 R9 unhalt resumes at first break PC
    '{1'b1,1'b0,32'h5, 1'b0,32'h0, 1'b0,12'h0,  1'b0,1'b0,1'b1,1'b0,5'h00,1'b1,12'h124, 4'd3},
    '{1'b1,1'b0,32'h8, 1'b0,32'h0, 1'b0,12'h0,  1'b0,1'b0,1'b0,1'b0,5'h00,1'b0,12'h000, 4'd6},
    // R4 break in delay slot, enable clear: no request
    '{1'b0,1'b0,32'h0, 1'b0,32'h0, 1'b1,12'h088,1'b1,1'b1,1'b0,1'b0,5'h07,1'b0,12'h000, 4'd4},
    // R5 host PC write while halted
    '{1'b1,1'b1,32'hABE,1'b0,32'h0,1'b0,12'h0,  1'b1,1'b1,1'b0,1'b0,5'h1F,1'b1,12'hABC, 4'd5},
    // R5 unhalt uses host PC, not delay-slot target
    '{1'b1,1'b0,32'h5, 1'b0,32'h0, 1'b0,12'h0,  1'b0,1'b0,1'b0,1'b0,5'h00,1'b1,12'hABC, 4'd5},
    // R7 core word with bit 31 sets halt only
    '{1'b0,1'b0,32'h0, 1'b1,32'h80000002,1'b0,12'h0,1'b1,1'b0,1'b0,1'b0,5'h00,1'b0,12'h000, 4'd7},
    // R7 host word with bit 31 clears halt, broke stays 0
    '{1'b1,1'b0,32'h80000001,1'b0,32'h0,1'b0,12'h0,1'b0,1'b0,1'b0,1'b0,5'h00,1'b1,12'hABC, 4'd7},
    // R8 core and host in same cycle
    '{1'b1,1'b0,32'h10,1'b1,32'h2, 1'b0,12'h0,  1'b1,1'b0,1'b1,1'b0,5'h00,1'b0,12'h000, 4'd8},
    // R6 set and clear halt together
    '{1'b1,1'b0,32'h3, 1'b0,32'h0, 1'b0,12'h0,  1'b0,1'b0,1'b1,1'b0,5'h00,1'b1,12'hABC, 4'd6},
    // R6 core set and clear enable together
    '{1'b0,1'b0,32'h0, 1'b1,32'h18,1'b0,12'h0,  1'b0,1'b0,1'b0,1'b0,5'h00,1'b0,12'h000, 4'd6},
    // R5 host PC write beats break in same cycle
    '{1'b1,1'b1,32'h40,1'b0,32'h0, 1'b1,12'h3FC,1'b1,1'b1,1'b0,1'b0,5'h1F,1'b1,12'h040, 4'd5},
    '{1'b1,1'b0,32'h1, 1'b0,32'h0, 1'b0,12'h0,  1'b0,1'b1,1'b0,1'b0,5'h00,1'b1,12'h040, 4'd5}
  };

  task automatic chk(input string what, input int req, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    host_wr_i = 0; host_addr_i = 0; host_data_i = 0;
    core_st_wr_i = 0; core_st_data_i = 0; ex_brk_i = 0; ex_next_pc_i = 0;
  endtask

  task automatic check_reset_state();  // R1
    chk("halt", 1, 32'(halt_o), 1);
    chk("broke", 1, 32'(broke_o), 0);
    chk("ien", 1, 32'(brk_irq_en_o), 0);
    chk("irq", 1, 32'(irq_o), 0);
    chk("flush", 1, 32'(flush_o), 0);
    chk("redirect", 1, 32'(redirect_o), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; idle_inputs();
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL R1 watchdog got=hang exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1; idle_inputs();
    do_reset();
    check_reset_state();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      host_wr_i = VEC[i].hw; host_addr_i = VEC[i].ha; host_data_i = VEC[i].hd;
      core_st_wr_i = VEC[i].cw; core_st_data_i = VEC[i].cd;
      ex_brk_i = VEC[i].bk; ex_next_pc_i = VEC[i].npc;
      @(posedge clk); #1;
      chk($sformatf("v%0d halt", i), VEC[i].req, 32'(halt_o), 32'(VEC[i].eh));
      chk($sformatf("v%0d broke", i), VEC[i].req, 32'(broke_o), 32'(VEC[i].eb));
      chk($sformatf("v%0d ien", i), VEC[i].req, 32'(brk_irq_en_o), 32'(VEC[i].ei));
      chk($sformatf("v%0d irq", i), VEC[i].req, 32'(irq_o), 32'(VEC[i].eirq));
      chk($sformatf("v%0d flush", i), VEC[i].req, 32'(flush_o), 32'(VEC[i].ef));
      chk($sformatf("v%0d redirect", i), VEC[i].req, 32'(redirect_o), 32'(VEC[i].er));
      if (VEC[i].er)
        chk($sformatf("v%0d rpc", i), VEC[i].req, 32'(redirect_pc_o), 32'(VEC[i].erpc));
    end
    // R1: reset from a running, broke state restores the reset values
    @(negedge clk); idle_inputs();
    do_reset();
    check_reset_state();
    // R1: resume PC returns to 0 after reset
    host_wr_i = 1; host_data_i = 32'h1;
    @(posedge clk); #1;
    chk("rpc after reset", 1, 32'(redirect_pc_o), 0);
    chk("redirect after reset", 1, 32'(redirect_o), 1);
    @(negedge clk); idle_inputs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule